// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the two square-wave channels of an incremental encoder into a binary position count. Each raw channel is first brought into the clock domain by a short synchroniser chain. A run-length level filter then accepts a new level only when that level has been seen on several consecutive clock edges, so short noise spikes never reach the decoder. The filtered channel pair is compared with its value from the previous clock. A single-channel change in one rotational order counts up, and the opposite order counts down. Decoding is four counts per encoder cycle.

The count is a free-running up/down counter that wraps at full scale in both directions. Software that samples it at least once every half full scale can rebuild absolute position from two's-complement differences. A cyclic system can instead clear it with the reset once per cycle. A one-clock count-enable strobe and a direction level are brought out for observation. When both filtered channels change on the same clock, the block flags an illegal jump for one clock and does not count.

Top module: `qdec_position_counter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `position_o` is zero and `cnt_en_o` and `jump_err_o` are low.
- R2: A raw channel level reaches the decoder only when it has been held for three consecutive clock edges after synchronisation. A raw pulse lasting one or two clocks produces no count. A pulse lasting three clocks is accepted and is then undone by the return edge, which gives two counts and a net change of zero.
- R3: After a raw channel change, the count changes within at most seven clock periods.
- R4: Each accepted change of exactly one filtered channel raises `cnt_en_o` for exactly one clock and changes `position_o` by exactly one on the next edge. The count changes at no other time.
- R5: The channel state is written {A,B}. The order 00, 01, 11, 10, 00 counts up, and `cnt_dir_o` is 1 during the enable strobe. The reverse order counts down, and `cnt_dir_o` is 0.
- R6: The counter is `CNT_W` bits wide (default 16). Counting down from zero gives 2^CNT_W-1, and counting up from 2^CNT_W-1 gives zero.
- R7: When both filtered channels change on the same clock, `jump_err_o` is high for exactly one clock, `cnt_en_o` stays low and `position_o` is unchanged.
- R8: Asserting the active-low reset during operation clears `position_o` to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all state |
| enc_a | input | 1 | Raw encoder channel A |
| enc_b | input | 1 | Raw encoder channel B |
| position_o | output | CNT_W | Current up/down position count |
| cnt_en_o | output | 1 | One-clock strobe: the count changes on the next edge |
| cnt_dir_o | output | 1 | Direction of the current move, 1 = up |
| jump_err_o | output | 1 | One-clock flag for a simultaneous change of both channels |

## Verification
A wrong filter state shows up as an extra or a missing `cnt_en_o` pulse about six clocks after the glitch that caused it. A stale previous-state register shows up as a wrong direction, or as a false `jump_err_o`, on the very next move. Both errors leave `position_o` off by a fixed amount, and no later correct move repairs that. The bench therefore compares the count against its own Gray-order model after every single move, rather than only at the end of a run. It also counts enable and jump pulses, so that an error that cancels out in the count is still reported.

// File: rtl/qdec_pkg.sv
`timescale 1ns/1ps
package qdec_pkg;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2,
    MV_JUMP = 2'd3
  } move_e;

  // Position of a {A,B} pair along the counting-up cycle 00,01,11,10.
  function automatic logic [1:0] ring_pos(input logic [1:0] ab);
    logic [1:0] p;
    case (ab)
      2'b00:   p = 2'd0;
      2'b01:   p = 2'd1;
      2'b11:   p = 2'd2;
      default: p = 2'd3;
    endcase
    return p;
  endfunction

  // Classify the move from one filtered state to the next.
  function automatic move_e classify(input logic [1:0] prev_ab,
                                     input logic [1:0] cur_ab);
    logic [1:0] d;
    move_e m;
    d = ring_pos(cur_ab) - ring_pos(prev_ab);
    case (d)
      2'd0:    m = MV_NONE;
      2'd1:    m = MV_UP;
      2'd3:    m = MV_DOWN;
      default: m = MV_JUMP;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/qdec_sync.sv
`timescale 1ns/1ps
module qdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_filter.sv
`timescale 1ns/1ps
module qdec_filter #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int HW = RUN - 1;

  logic [HW-1:0] hist_q;
  logic          agree_hi;
  logic          agree_lo;

  // The current sample plus RUN-1 earlier samples must all agree.
  assign agree_hi = d & (&hist_q);
  assign agree_lo = ~d & ~(|hist_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      q      <= 1'b0;
    end else begin
      hist_q[0] <= d;
      for (int i = 1; i < HW; i++) begin
        hist_q[i] <= hist_q[i-1];
      end
      if (agree_hi) begin
        q <= 1'b1;
      end else if (agree_lo) begin
        q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qdec_decode.sv
`timescale 1ns/1ps
module qdec_decode
  import qdec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  filt_ab,
  output logic [1:0]  prev_ab,
  output move_e       move
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ab <= 2'b00;
    end else begin
      prev_ab <= filt_ab;
    end
  end

  assign move = classify(prev_ab, filt_ab);
endmodule

// File: rtl/qdec_counter.sv
`timescale 1ns/1ps
module qdec_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] cur,
                                            input logic             inc);
    return inc ? cur + 1'b1 : cur - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= bump(count, up);
    end
  end
endmodule

// File: rtl/qdec_position_counter.sv
`timescale 1ns/1ps
module qdec_position_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_RUN  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic [CNT_W-1:0] position_o,
  output logic             cnt_en_o,
  output logic             cnt_dir_o,
  output logic             jump_err_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_ab;
  logic [NCH-1:0] sync_ab;
  logic [NCH-1:0] filt_ab;
  logic [1:0]     prev_ab;
  move_e          move;
  logic           step_up;
  logic           step_dn;
  logic           step_jump;

  // Bit 1 carries channel A, bit 0 carries channel B.
  assign raw_ab = {enc_a, enc_b};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_ab[c]),
      .q     (sync_ab[c])
    );
    qdec_filter #(.RUN(FILTER_RUN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_ab[c]),
      .q     (filt_ab[c])
    );
  end

  qdec_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .filt_ab (filt_ab),
    .prev_ab (prev_ab),
    .move    (move)
  );

  assign step_up   = (move == MV_UP);
  assign step_dn   = (move == MV_DOWN);
  assign step_jump = (move == MV_JUMP);

  qdec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step_up | step_dn),
    .up    (step_up),
    .count (position_o)
  );

  assign cnt_en_o   = step_up | step_dn;
  assign cnt_dir_o  = step_up;
  assign jump_err_o = step_jump;
endmodule

// File: rtl/qdec_checker.sv
`timescale 1ns/1ps
module qdec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sync_ab,
  input logic [1:0]       filt_ab,
  input logic [CNT_W-1:0] position_o,
  input logic             cnt_en_o,
  input logic             cnt_dir_o,
  input logic             jump_err_o
);
  // R2
  filt_a_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_ab[1]) |-> ($past(sync_ab[1]) == filt_ab[1] &&
                             $past(sync_ab[1], 2) == filt_ab[1] &&
                             $past(sync_ab[1], 3) == filt_ab[1]));
  // R2
  filt_b_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_ab[0]) |-> ($past(sync_ab[0]) == filt_ab[0] &&
                             $past(sync_ab[0], 2) == filt_ab[0] &&
                             $past(sync_ab[0], 3) == filt_ab[0]));
  // R4
  count_only_on_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(position_o) |-> $past(cnt_en_o));
  // R4
  en_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_o |=> !cnt_en_o);
  // R5
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_o && cnt_dir_o) |=> position_o == CNT_W'($past(position_o) + 1'b1));
  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_o && !cnt_dir_o) |=> position_o == CNT_W'($past(position_o) - 1'b1));
  // R7
  jump_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_err_o |=> ($stable(position_o) && !jump_err_o));
  // R7
  jump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_err_o && cnt_en_o));
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (position_o == '0));
endmodule

bind qdec_position_counter qdec_checker #(.CNT_W(CNT_W)) u_qdec_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_ab    (sync_ab),
  .filt_ab    (filt_ab),
  .position_o (position_o),
  .cnt_en_o   (cnt_en_o),
  .cnt_dir_o  (cnt_dir_o),
  .jump_err_o (jump_err_o)
);

// File: tb/test_qdec_position_counter.sv
`timescale 1ns/1ps
module test_qdec_position_counter;
  localparam int CW = 16;
  localparam longint FULL = longint'(1) << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enc_a = 1'b0;
  logic          enc_b = 1'b0;
  logic [CW-1:0] position_o;
  logic          cnt_en_o;
  logic          cnt_dir_o;
  logic          jump_err_o;

  int total = 0;
  int bad   = 0;
  int n_en  = 0;
  int n_jmp = 0;
  logic last_dir = 1'b0;
  longint exp_pos = 0;
  int idx = 0;
  bit done = 0;
  logic [1:0] seq [4];

  always #2.5 clk = ~clk;

  qdec_position_counter #(.CNT_W(CW)) i_qdec_position_counter (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .position_o(position_o), .cnt_en_o(cnt_en_o),
    .cnt_dir_o(cnt_dir_o), .jump_err_o(jump_err_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cnt_en_o) begin
        n_en++;
        last_dir = cnt_dir_o;
      end
      if (jump_err_o) n_jmp++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One legal move along the Gray ring; delta is +1 (up) or -1 (down).
  task automatic move(input int delta);
    int ni;
    int en0;
    int lat;
    logic [CW-1:0] c0;
    ni  = (idx + delta + 4) % 4;
    en0 = n_en;
    c0  = position_o;
    lat = 0;
    @(negedge clk);
    enc_a = seq[ni][1];
    enc_b = seq[ni][0];
    for (int i = 1; i <= 12; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (lat == 0 && position_o != c0) lat = i;
    end
    idx = ni;
    exp_pos = (exp_pos + delta + FULL) % FULL;
    chk(position_o == CW'(exp_pos), "R4 count", position_o, exp_pos);
    chk(n_en - en0 == 1, "R4 enable pulses", n_en - en0, 1);
    chk(last_dir == (delta > 0), "R5 direction", last_dir, delta > 0);
    chk(lat >= 3 && lat <= 7, "R3 latency", lat, 6);
  endtask

  // Flip channel A for n clocks, then restore it.
  task automatic glitch(input int n, input int exp_en);
    int en0;
    en0 = n_en;
    @(negedge clk);
    enc_a = ~enc_a;
    repeat (n) @(negedge clk);
    enc_a = ~enc_a;
    settle(14);
    chk(n_en - en0 == exp_en, "R2 filter pulses", n_en - en0, exp_en);
    chk(position_o == CW'(exp_pos), "R2 count after glitch", position_o, exp_pos);
  endtask

  initial begin
    seq[0] = 2'b00; seq[1] = 2'b01; seq[2] = 2'b11; seq[3] = 2'b10;
    settle(3);
    chk(position_o == 0, "R1 reset count", position_o, 0);
    chk(cnt_en_o == 0, "R1 reset enable", cnt_en_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(position_o == 0 && !cnt_en_o && !jump_err_o, "R1 after release", position_o, 0);

    for (int k = 0; k < 8; k++) move(1);
    for (int k = 0; k < 12; k++) move(-1);
    chk(position_o == CW'(FULL - 4), "R6 wrap below zero", position_o, FULL - 4);
    for (int k = 0; k < 4; k++) move(1);
    chk(position_o == 0, "R6 back to zero", position_o, 0);
    move(-1);
    chk(position_o == CW'(FULL - 1), "R6 zero minus one", position_o, FULL - 1);
    move(1);
    chk(position_o == 0, "R6 full scale plus one", position_o, 0);

    glitch(1, 0);
    glitch(2, 0);
    glitch(3, 2);

    begin : jump_case
      int en0;
      int j0;
      en0 = n_en;
      j0  = n_jmp;
      @(negedge clk);
      enc_a = ~enc_a;
      enc_b = ~enc_b;
      settle(14);
      idx = (idx + 2) % 4;
      chk(n_jmp - j0 == 1, "R7 jump pulses", n_jmp - j0, 1);
      chk(n_en - en0 == 0, "R7 no enable", n_en - en0, 0);
      chk(position_o == CW'(exp_pos), "R7 count held", position_o, exp_pos);
    end
    move(1);
    move(-1);

    for (int k = 0; k < 3; k++) move(1);
    while (idx != 0) move(-1);
    if (exp_pos == 0) begin
      for (int k = 0; k < 4; k++) move(1);
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(position_o == 0, "R8 reset clears", position_o, 0);
    settle(2);
    rst_n = 1'b1;
    exp_pos = 0;
    settle(2);
    move(1);
    chk(position_o == 1, "R8 counts after reset", position_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule